// File: doc/BRIEF.md
# UART Port Register Interface

This block is the processor-side register set of a single serial port. It sits on a simple byte-wide bus with an address, a read strobe, a write strobe, write data and registered read data. Two addresses are decoded. The status address reports whether a received character is waiting and whether the transmitter can take a new one. A single data address is shared: a read returns the receive buffer, and a write loads the transmitter.

Received characters come from a separate receiver core as a one-cycle strobe with a byte. The block latches the byte and raises the receive-ready flag. Reading the data address consumes the character and drops that flag as a side effect. Characters to send are copied into a frame shifter. The shifter drives the serial output one bit per `BIT_CYCLES` clocks, and the transmit-ready flag stays low until the stop bit has finished. Software is expected to poll the status register before each data access.

Top module: `uart_port_regs`

## Requirements
- R1: After reset, `bus_rdata` is 0, `tx_line` is 1, and a status read returns 0x04 (transmit ready, nothing received).
- R2: A status read (address 0) returns bit 0 = receive-ready and bit 2 = transmit-ready, with all other bits 0.
- R3: Read data is registered. The value appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. A read of the data address (address 1) returns the receive buffer, and a read of any other address returns 0.
- R4: A read of the data address clears receive-ready at the same clock edge, unless a character is delivered in that same cycle.
- R5: A `rx_valid` pulse stores `rx_data` in the receive buffer and sets receive-ready. If receive-ready is already 1, the buffer is overwritten and the flag stays 1. If the pulse coincides with a data read, the read returns the old byte and the flag stays 1.
- R6: A write to the data address while transmit-ready is 1 sends one frame on `tx_line`, starting on the clock after the write. The frame is a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit, each bit lasting `BIT_CYCLES` clocks. `tx_line` idles at 1.
- R7: Transmit-ready is 0 from the clock after an accepted write for exactly 10×`BIT_CYCLES` clocks, then returns to 1.
- R8: A write to the data address while transmit-ready is 0 is ignored, and the frame in progress is unchanged.
- R9: Writes to the status address or to unused addresses change nothing: the status is unchanged and `tx_line` stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Receiver core delivers a character |
| rx_data | input | DATA_W | Character from the receiver core |
| tx_line | output | 1 | Serial transmit output, idle high |

## Verification
The properties assume that `rx_valid` is a single-cycle pulse per character, that `bus_rd` and `bus_wr` are never high in the same cycle, and that `bus_addr` is valid whenever a strobe is high. The stimulus drives each bus access as one isolated strobe cycle and never overlaps a read with a write. It issues receiver pulses as single cycles, including one timed to land on the same cycle as a data read, so that the collision rule is exercised inside those assumptions.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;
  localparam int STAT_RX_BIT = 0;
  localparam int STAT_TX_BIT = 2;
  localparam int CHAR_BITS   = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } sel_e;
endpackage

// File: rtl/uart_port_decode.sv
module uart_port_decode
  import uart_port_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_stat,
  output logic              rd_data,
  output logic              wr_data
);
  sel_e sel;

  always_comb begin
    if (addr == ADDR_W'(STAT_ADDR))      sel = SEL_STAT;
    else if (addr == ADDR_W'(DATA_ADDR)) sel = SEL_DATA;
    else                                 sel = SEL_NONE;
  end

  assign rd_stat = rd && (sel == SEL_STAT);
  assign rd_data = rd && (sel == SEL_DATA);
  assign wr_data = wr && (sel == SEL_DATA);
endmodule

// File: rtl/uart_port_rxbuf.sv
module uart_port_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deliver,
  input  logic [DATA_W-1:0] deliver_data,
  input  logic              consume,
  output logic              ready,
  output logic [DATA_W-1:0] held
);
  logic              flag_q, flag_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              buf_en;

  always_comb begin
    buf_en = deliver;
    buf_d  = deliver_data;
    if (deliver)      flag_d = 1'b1;
    else if (consume) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  assign ready = flag_q;
  assign held  = buf_q;
endmodule

// File: rtl/uart_port_txser.sv
module uart_port_txser #(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              ready,
  output logic              line
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int TW      = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int CW      = $clog2(FRAME_W);
  localparam logic [TW-1:0] RELOAD = TW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] LAST   = CW'(FRAME_W - 1);

  logic               busy_q, busy_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [TW-1:0]      timer_q, timer_d;
  logic [CW-1:0]      left_q, left_d;

  always_comb begin
    busy_d  = busy_q;
    frame_d = frame_q;
    timer_d = timer_q;
    left_d  = left_q;
    if (busy_q) begin
      if (timer_q == '0) begin
        if (left_q == '0) begin
          busy_d = 1'b0;
        end else begin
          frame_d = {1'b1, frame_q[FRAME_W-1:1]};
          left_d  = left_q - 1'b1;
          timer_d = RELOAD;
        end
      end else begin
        timer_d = timer_q - 1'b1;
      end
    end else if (load) begin
      busy_d  = 1'b1;
      frame_d = {1'b1, load_data, 1'b0};
      timer_d = RELOAD;
      left_d  = LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      timer_q <= '0;
      left_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      frame_q <= frame_d;
      timer_q <= timer_d;
      left_q  <= left_d;
    end
  end

  assign ready = !busy_q;
  assign line  = busy_q ? frame_q[0] : 1'b1;
endmodule

// File: rtl/uart_port_regs.sv
module uart_port_regs
  import uart_port_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int STAT_ADDR  = 0,
  parameter int DATA_ADDR  = 1,
  parameter int DATA_W     = CHAR_BITS,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_line
);
  logic              rd_stat, rd_data, wr_data;
  logic              rx_rdy, tx_rdy;
  logic [DATA_W-1:0] rx_buf;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  uart_port_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) dec_i (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .rd_stat(rd_stat), .rd_data(rd_data), .wr_data(wr_data)
  );

  uart_port_rxbuf #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .deliver(rx_valid), .deliver_data(rx_data),
    .consume(rd_data),
    .ready(rx_rdy), .held(rx_buf)
  );

  uart_port_txser #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES)) tx_i (
    .clk(clk), .rst_n(rst_n),
    .load(wr_data && tx_rdy), .load_data(bus_wdata),
    .ready(tx_rdy), .line(tx_line)
  );

  always_comb begin
    stat_word              = '0;
    stat_word[STAT_RX_BIT] = rx_rdy;
    stat_word[STAT_TX_BIT] = tx_rdy;
  end

  always_comb begin
    rdata_en = bus_rd;
    if (rd_stat)      rdata_d = stat_word;
    else if (rd_data) rdata_d = rx_buf;
    else              rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/uart_port_regs_chk.sv
module uart_port_regs_chk #(
  parameter int ADDR_W     = 2,
  parameter int STAT_ADDR  = 0,
  parameter int DATA_ADDR  = 1,
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              tx_line,
  input logic              rx_rdy,
  input logic [DATA_W-1:0] rx_buf,
  input logic              tx_rdy
);
  localparam logic [DATA_W-1:0] SPARE = ~(DATA_W'(1) | DATA_W'(4));
  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= 0;
    else if (tx_rdy) busy_cnt <= 0;
    else             busy_cnt <= busy_cnt + 1;
  end

  assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(STAT_ADDR)) |=> ((bus_rdata & SPARE) == '0));

  assert_data_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(DATA_ADDR)) |=> (bus_rdata == $past(rx_buf)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(DATA_ADDR) && !rx_valid) |=> !rx_rdy);

  assert_arrival_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_rdy);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rdy |-> tx_line);

  assert_busy_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(DATA_ADDR) && tx_rdy) |=> !tx_rdy);

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> (busy_cnt == 10 * BIT_CYCLES));

  assert_other_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != ADDR_W'(DATA_ADDR) && tx_rdy) |=> tx_rdy);
endmodule

bind uart_port_regs uart_port_regs_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR),
  .DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
  .tx_line(tx_line), .rx_rdy(rx_rdy), .rx_buf(rx_buf), .tx_rdy(tx_rdy)
);

// File: tb/uart_port_regs_tb_top.sv
module uart_port_regs_tb_top;
  localparam int B = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_line;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit live = 1'b0;

  always #10 clk = ~clk;

  uart_port_regs #(.BIT_CYCLES(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_line(tx_line)
  );

  // behavioural reference model
  bit       m_rx_rdy;
  int       m_buf, m_rdata, m_left;
  bit [9:0] m_frame;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx_rdy = 0; m_buf = 0; m_rdata = 0; m_left = 0; m_frame = '1;
    end else begin
      if (bus_rd) begin
        if (bus_addr == 0)      m_rdata = ((m_left == 0) ? 4 : 0) + (m_rx_rdy ? 1 : 0);
        else if (bus_addr == 1) m_rdata = m_buf;
        else                    m_rdata = 0;
      end
      if (m_left > 0) m_left--;
      if (bus_wr && bus_addr == 1 && m_left == 0) begin
        m_frame = {1'b1, bus_wdata, 1'b0};
        m_left  = 10 * B;
      end
      if (rx_valid) begin
        m_buf = rx_data; m_rx_rdy = 1;
      end else if (bus_rd && bus_addr == 1) begin
        m_rx_rdy = 0;
      end
    end
  end

  function automatic int exp_line();
    if (m_left == 0) return 1;
    return int'(m_frame[(10 * B - m_left) / B]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (live) begin
      chk(tx_line == exp_line(), "R6 line", int'(tx_line), exp_line());
      chk(bus_rdata == m_rdata[7:0], "R3 rdata", int'(bus_rdata), m_rdata);
    end
  end

  task automatic bus_read(input int a, input int exp, input string req);
    @(negedge clk);
    bus_addr = 2'(a); bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    chk(bus_rdata == 8'(exp), req, int'(bus_rdata), exp);
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic deliver(input int d);
    @(negedge clk);
    rx_valid = 1; rx_data = 8'(d);
    @(negedge clk);
    rx_valid = 0;
  endtask

  // write a byte, capture the frame mid-bit, optionally poke a write while busy
  task automatic send_capture(input int d, input bit poke, input string req);
    bit [9:0] got;
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'(d); bus_wr = 1;
    for (int k = 0; k < 10 * B; k++) begin
      @(negedge clk);
      bus_wr = 0;
      if (k % B == B / 2) got[k / B] = tx_line;
      if (poke && k == 3) begin
        bus_addr = 2'd1; bus_wdata = 8'hC3; bus_wr = 1;
      end
    end
    @(negedge clk);
    bus_wr = 0;
    chk(got == {1'b1, 8'(d), 1'b0}, req, int'(got), int'({1'b1, 8'(d), 1'b0}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    chk(bus_rdata == 0 && tx_line == 1, "R1 reset outputs", int'({tx_line, bus_rdata}), 'h100);
    bus_read(0, 'h04, "R1 reset status");
    // receive path
    deliver('hA5);
    bus_read(0, 'h05, "R2 status rx ready");
    bus_read(1, 'hA5, "R3 data read");
    bus_read(0, 'h04, "R4 flag cleared");
    deliver('h11);
    deliver('h22);
    bus_read(0, 'h05, "R5 still ready after overwrite");
    bus_read(1, 'h22, "R5 overwrite");
    // collision: delivery on the same cycle as a data read
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1; rx_valid = 1; rx_data = 8'h33;
    @(negedge clk);
    bus_rd = 0; rx_valid = 0;
    chk(bus_rdata == 8'h22, "R5 collision returns old", int'(bus_rdata), 'h22);
    bus_read(0, 'h05, "R5 collision flag kept");
    bus_read(1, 'h33, "R5 collision new byte");
    bus_read(2, 'h00, "R3 unused address");
    bus_read(3, 'h00, "R3 unused address");
    // transmit path
    send_capture('h5A, 0, "R6 frame 0x5A");
    send_capture('h81, 1, "R8 busy write ignored");
    send_capture('h00, 0, "R6 frame 0x00");
    bus_write(1, 'hFF);
    bus_read(0, 'h00, "R7 busy after write");
    repeat (10 * B) @(negedge clk);
    bus_read(0, 'h04, "R7 ready after stop");
    // writes elsewhere have no effect
    bus_write(0, 'hFF);
    bus_write(2, 'h00);
    chk(tx_line == 1, "R9 line idle", int'(tx_line), 1);
    bus_read(0, 'h04, "R9 status unchanged");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<=20000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule